// File: doc/BRIEF.md
# Level-Grouped Interrupt Request Controller

This block collects interrupt requests from a flat set of sources organised as several 32-bit level words; a source's flat index is its level times 32 plus its bit within the word. Each source has a request bit and an enable bit. A single `pending` output reports whether any source is both requesting and enabled.

An acknowledge strobe picks the winning source, clears its request and returns a device number one cycle later. The winner is the lowest enabled, requesting bit of the lowest level. The device number comes from a small table that is filled at configuration time. Per-source commands enable, disable or disarm a source. A separate update port can keep, set, clear or toggle a request bit directly.

Top module: `irqc_top`

## Requirements
- R1: After reset every request bit is 0, every enable bit is 1 and every device-table entry is 0. `pending`, `ack_valid`, `ack_dev` and `cmd_rsp_valid` are all 0.
- R2: A 1 on `req_set[i]` sets the request bit of flat source i (i = level*32 + bit). The new state is visible on `pending` in the cycle after the edge that captures it.
- R3: `pending` is 1 exactly when at least one source has both its request bit and its enable bit at 1.
- R4: An acknowledge selects the lowest level that has an enabled request, and within that level the lowest such bit.
- R5: The acknowledge result is registered. `ack_valid` is 1 for the one cycle after each `ack_stb` cycle, and `ack_dev` then shows the table entry of the winner. Only the winner's request bit is cleared; other requests stay set.
- R6: An acknowledge while nothing is pending returns `ack_dev` = 0 and changes no request bit.
- R7: If `req_set` and an acknowledge clear the same bit in the same cycle, the bit stays set.
- R8: Command code `cmd_op` 1 sets the enable bit of `cmd_src`, 2 clears it, and 3 clears both the enable bit and the request bit. Code 0 changes nothing.
- R9: Each command produces a registered response one cycle later with `cmd_rsp_valid` = 1. `cmd_rsp_arm` is 1 for codes 1 and 2, 0 for code 3, and equal to `cmd_arm_prev` for code 0.
- R10: The update port applies `upd_op` to the request bit of `upd_src`: 0 keep, 1 set, 2 clear, 3 toggle.
- R11: With `map_we` = 1, `map_dev` is written into the table entry `map_idx`. Later acknowledges of that source return it.
- R12: A requesting source whose enable bit is 0 does not raise `pending` and is skipped by the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | NSRC | Per-source request set pulses |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_dev | output | DEV_W | Device number of the acknowledged source |
| pending | output | 1 | Some enabled request is set |
| cmd_stb | input | 1 | Control command strobe |
| cmd_src | input | IDX_W | Flat source index for the command |
| cmd_op | input | 2 | Command code (0 none, 1 enable, 2 disable, 3 disarm) |
| cmd_arm_prev | input | 1 | Arm state returned for code 0 |
| cmd_rsp_valid | output | 1 | Command response valid |
| cmd_rsp_arm | output | 1 | Arm state returned by the command |
| upd_stb | input | 1 | Request-bit update strobe |
| upd_src | input | IDX_W | Flat source index to update |
| upd_op | input | 2 | Update code (0 keep, 1 set, 2 clear, 3 toggle) |
| map_we | input | 1 | Device table write enable |
| map_idx | input | IDX_W | Device table entry to write |
| map_dev | input | DEV_W | Device number to store |

## Verification
Sets, commands and updates change registered bits at one clock edge, so their effect on `pending` is due one cycle after the stimulus. Acknowledge and command responses are also due exactly one cycle after their strobe. The bench drives every input on the falling edge and holds it across one rising edge. It checks `pending` on the next falling edge. A monitor compares each `ack_valid` or `cmd_rsp_valid` pulse, also on the falling edge, against the expectation the driver queued before raising the strobe. Any response with no queued expectation, and any expectation left in a queue at the end, counts as a miscompare.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int WORD_W = 32;
    localparam int BIT_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        CTL_NONE   = 2'd0,
        CTL_ARM_ON = 2'd1,
        CTL_ARM_OFF= 2'd2,
        CTL_DISARM = 2'd3
    } ctl_op_e;

    typedef enum logic [1:0] {
        UPD_KEEP = 2'd0,
        UPD_SET  = 2'd1,
        UPD_CLR  = 2'd2,
        UPD_FLIP = 2'd3
    } upd_op_e;

    function automatic logic upd_bit(input upd_op_e op, input logic cur);
        case (op)
            UPD_SET:  return 1'b1;
            UPD_CLR:  return 1'b0;
            UPD_FLIP: return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/irqc_level.sv
module irqc_level
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] set_w,
    input  logic [WORD_W-1:0] ack_clr_w,
    input  logic [WORD_W-1:0] upd_sel_w,
    input  logic [1:0]        upd_op,
    input  logic [WORD_W-1:0] cmd_sel_w,
    input  logic [1:0]        cmd_op,
    output logic [WORD_W-1:0] req_q,
    output logic [WORD_W-1:0] en_q,
    output logic              hit,
    output logic [BIT_W-1:0]  first_bit
);

    logic [WORD_W-1:0] req_d, en_d, act;

    always_comb begin
        for (int b = 0; b < WORD_W; b++) begin
            req_d[b] = req_q[b] & ~ack_clr_w[b];
            en_d[b]  = en_q[b];
            if (upd_sel_w[b]) req_d[b] = upd_bit(upd_op_e'(upd_op), req_d[b]);
            if (cmd_sel_w[b]) begin
                case (ctl_op_e'(cmd_op))
                    CTL_ARM_ON:  en_d[b] = 1'b1;
                    CTL_ARM_OFF: en_d[b] = 1'b0;
                    CTL_DISARM: begin
                        en_d[b]  = 1'b0;
                        req_d[b] = 1'b0;
                    end
                    default: ;
                endcase
            end
            if (set_w[b]) req_d[b] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            en_q  <= '1;
        end else begin
            req_q <= req_d;
            en_q  <= en_d;
        end
    end

    assign act = req_q & en_q;
    assign hit = |act;

    always_comb begin
        first_bit = '0;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            if (act[b]) first_bit = BIT_W'(b);
        end
    end

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int LEVELS = 2,
    localparam int IDX_W = $clog2(LEVELS * WORD_W)
) (
    input  logic [LEVELS-1:0]            hit,
    input  logic [LEVELS-1:0][BIT_W-1:0] first_bits,
    output logic                         any,
    output logic [IDX_W-1:0]             win_idx
);

    assign any = |hit;

    always_comb begin
        win_idx = '0;
        for (int l = LEVELS - 1; l >= 0; l--) begin
            if (hit[l]) win_idx = IDX_W'(l * WORD_W) + IDX_W'(first_bits[l]);
        end
    end

endmodule

// File: rtl/irqc_devmap.sv
module irqc_devmap #(
    parameter int NSRC  = 64,
    parameter int DEV_W = 8,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DEV_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DEV_W-1:0] rdata
);

    logic [DEV_W-1:0] tbl [NSRC];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSRC; i++) tbl[i] <= '0;
        end else if (we) begin
            tbl[widx] <= wdata;
        end
    end

    assign rdata = tbl[ridx];

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int LEVELS = 2,
    parameter int DEV_W  = 8,
    localparam int NSRC  = LEVELS * WORD_W,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  req_set,
    input  logic             ack_stb,
    output logic             ack_valid,
    output logic [DEV_W-1:0] ack_dev,
    output logic             pending,
    input  logic             cmd_stb,
    input  logic [IDX_W-1:0] cmd_src,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_arm_prev,
    output logic             cmd_rsp_valid,
    output logic             cmd_rsp_arm,
    input  logic             upd_stb,
    input  logic [IDX_W-1:0] upd_src,
    input  logic [1:0]       upd_op,
    input  logic             map_we,
    input  logic [IDX_W-1:0] map_idx,
    input  logic [DEV_W-1:0] map_dev
);

    logic [NSRC-1:0]             req_all, en_all, ack_clr, upd_sel, cmd_sel;
    logic [LEVELS-1:0]           lvl_hit;
    logic [LEVELS-1:0][BIT_W-1:0] lvl_first;
    logic                        win_any;
    logic [IDX_W-1:0]            win_idx;
    logic [DEV_W-1:0]            win_dev;

    assign upd_sel = upd_stb ? (NSRC'(1) << upd_src) : '0;
    assign cmd_sel = cmd_stb ? (NSRC'(1) << cmd_src) : '0;
    assign ack_clr = (ack_stb && win_any) ? (NSRC'(1) << win_idx) : '0;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        irqc_level u_level (
            .clk       (clk),
            .rst       (rst),
            .set_w     (req_set[l*WORD_W +: WORD_W]),
            .ack_clr_w (ack_clr[l*WORD_W +: WORD_W]),
            .upd_sel_w (upd_sel[l*WORD_W +: WORD_W]),
            .upd_op    (upd_op),
            .cmd_sel_w (cmd_sel[l*WORD_W +: WORD_W]),
            .cmd_op    (cmd_op),
            .req_q     (req_all[l*WORD_W +: WORD_W]),
            .en_q      (en_all[l*WORD_W +: WORD_W]),
            .hit       (lvl_hit[l]),
            .first_bit (lvl_first[l])
        );
    end

    irqc_pick #(.LEVELS(LEVELS)) u_pick (
        .hit        (lvl_hit),
        .first_bits (lvl_first),
        .any        (win_any),
        .win_idx    (win_idx)
    );

    irqc_devmap #(.NSRC(NSRC), .DEV_W(DEV_W)) u_map (
        .clk   (clk),
        .rst   (rst),
        .we    (map_we),
        .widx  (map_idx),
        .wdata (map_dev),
        .ridx  (win_idx),
        .rdata (win_dev)
    );

    assign pending = win_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_valid     <= 1'b0;
            ack_dev       <= '0;
            cmd_rsp_valid <= 1'b0;
            cmd_rsp_arm   <= 1'b0;
        end else begin
            ack_valid     <= ack_stb;
            cmd_rsp_valid <= cmd_stb;
            if (ack_stb) ack_dev <= win_any ? win_dev : '0;
            if (cmd_stb) begin
                case (ctl_op_e'(cmd_op))
                    CTL_ARM_ON, CTL_ARM_OFF: cmd_rsp_arm <= 1'b1;
                    CTL_DISARM:              cmd_rsp_arm <= 1'b0;
                    default:                 cmd_rsp_arm <= cmd_arm_prev;
                endcase
            end
        end
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NSRC  = 64,
    parameter int DEV_W = 8,
    localparam int IDX_W = $clog2(NSRC)
) (
    input logic             clk,
    input logic             rst,
    input logic [NSRC-1:0]  req_set,
    input logic             ack_stb,
    input logic             ack_valid,
    input logic [DEV_W-1:0] ack_dev,
    input logic             pending,
    input logic             cmd_stb,
    input logic [IDX_W-1:0] cmd_src,
    input logic [1:0]       cmd_op,
    input logic [NSRC-1:0]  req_all,
    input logic [NSRC-1:0]  en_all
);

    p_pending_match_r3: assert property (@(posedge clk) disable iff (rst)
        pending == (|(req_all & en_all)));

    p_set_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (|req_set) |=> ((req_all & $past(req_set)) == $past(req_set)));

    p_ack_valid_r5: assert property (@(posedge clk) disable iff (rst)
        ack_stb |=> ack_valid);

    p_no_ack_valid_r5: assert property (@(posedge clk) disable iff (rst)
        !ack_stb |=> !ack_valid);

    p_idle_ack_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_stb && !pending) |=> (ack_dev == '0));

    p_enable_cmd_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_op == 2'd1) |=> en_all[$past(cmd_src)]);

    p_disarm_cmd_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_op == 2'd3 && !req_set[cmd_src])
        |=> (!en_all[$past(cmd_src)] && !req_all[$past(cmd_src)]));

endmodule

bind irqc_top irqc_checker #(.NSRC(NSRC), .DEV_W(DEV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_set   (req_set),
    .ack_stb   (ack_stb),
    .ack_valid (ack_valid),
    .ack_dev   (ack_dev),
    .pending   (pending),
    .cmd_stb   (cmd_stb),
    .cmd_src   (cmd_src),
    .cmd_op    (cmd_op),
    .req_all   (req_all),
    .en_all    (en_all)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;

    localparam int NSRC  = 64;
    localparam int IDX_W = 6;
    localparam int DEV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NSRC-1:0]  req_set = '0;
    logic             ack_stb = 1'b0;
    logic             ack_valid;
    logic [DEV_W-1:0] ack_dev;
    logic             pending;
    logic             cmd_stb = 1'b0;
    logic [IDX_W-1:0] cmd_src = '0;
    logic [1:0]       cmd_op = '0;
    logic             cmd_arm_prev = 1'b0;
    logic             cmd_rsp_valid;
    logic             cmd_rsp_arm;
    logic             upd_stb = 1'b0;
    logic [IDX_W-1:0] upd_src = '0;
    logic [1:0]       upd_op = '0;
    logic             map_we = 1'b0;
    logic [IDX_W-1:0] map_idx = '0;
    logic [DEV_W-1:0] map_dev = '0;

    always #5 clk = ~clk;

    irqc_top #(.LEVELS(2), .DEV_W(DEV_W)) u_irqc_top (.*);

    typedef struct {
        int    val;
        string tag;
    } exp_t;

    exp_t ack_q[$];
    exp_t rsp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    // Monitor: compares registered responses with queued expectations.
    always @(negedge clk) begin
        if (!rst) begin
            if (ack_valid) begin
                if (ack_q.size() == 0) check(1'b0, "R5 unexpected ack", int'(ack_dev), -1);
                else begin
                    exp_t e;
                    e = ack_q.pop_front();
                    chk_eq(e.tag, int'(ack_dev), e.val);
                end
            end
            if (cmd_rsp_valid) begin
                if (rsp_q.size() == 0) check(1'b0, "R9 unexpected response", int'(cmd_rsp_arm), -1);
                else begin
                    exp_t e;
                    e = rsp_q.pop_front();
                    chk_eq(e.tag, int'(cmd_rsp_arm), e.val);
                end
            end
        end
    end

    function automatic int dev_of(input int idx);
        return (idx + 8'h40) & 8'hFF;
    endfunction

    task automatic step();
        @(negedge clk);
        req_set = '0; ack_stb = 0; cmd_stb = 0; upd_stb = 0; map_we = 0;
    endtask

    task automatic raise(input logic [NSRC-1:0] mask);
        req_set = mask;
        step();
    endtask

    task automatic do_ack(input int exp, input string tag);
        ack_q.push_back('{exp, tag});
        ack_stb = 1'b1;
        step();
    endtask

    task automatic do_cmd(input int src, input int op, input bit prev, input int exp, input string tag);
        rsp_q.push_back('{exp, tag});
        cmd_stb = 1'b1; cmd_src = IDX_W'(src); cmd_op = 2'(op); cmd_arm_prev = prev;
        step();
    endtask

    task automatic do_upd(input int src, input int op);
        upd_stb = 1'b1; upd_src = IDX_W'(src); upd_op = 2'(op);
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk_eq("R1 pending", int'(pending), 0);
        chk_eq("R1 ack_valid", int'(ack_valid), 0);
        chk_eq("R1 ack_dev", int'(ack_dev), 0);
        chk_eq("R1 cmd_rsp_valid", int'(cmd_rsp_valid), 0);

        // R2/R3: a set request raises pending; table is still all zero (R1)
        raise(NSRC'(1) << 5);
        chk_eq("R2 pending after set", int'(pending), 1);
        do_ack(0, "R1 table entry zero after reset");
        chk_eq("R5 request cleared by ack", int'(pending), 0);

        // R11: fill the device table
        for (int i = 0; i < NSRC; i++) begin
            map_we = 1'b1; map_idx = IDX_W'(i); map_dev = DEV_W'(dev_of(i));
            step();
        end

        // R4: priority by level, then bit
        raise((NSRC'(1) << 40) | (NSRC'(1) << 3) | (NSRC'(1) << 33));
        do_ack(dev_of(3), "R4 lowest level bit 3 first");
        do_ack(dev_of(33), "R4 level 1 bit 1 next");
        do_ack(dev_of(40), "R4 level 1 bit 8 last");
        chk_eq("R3 nothing left pending", int'(pending), 0);
        do_ack(0, "R6 ack with nothing pending");
        chk_eq("R6 still nothing pending", int'(pending), 0);

        // R12: disabled source is skipped
        do_cmd(2, 2, 1'b0, 1, "R9 disable responds 1");
        raise((NSRC'(1) << 2) | (NSRC'(1) << 50));
        do_ack(dev_of(50), "R12 disabled source 2 skipped");
        chk_eq("R12 disabled request not pending", int'(pending), 0);
        do_cmd(2, 1, 1'b0, 1, "R9 enable responds 1");
        chk_eq("R8 enable exposes held request", int'(pending), 1);
        do_ack(dev_of(2), "R8 re-enabled source acknowledged");

        // R8: disarm drops enable and request
        raise(NSRC'(1) << 7);
        do_cmd(7, 3, 1'b1, 0, "R9 disarm responds 0");
        chk_eq("R8 disarm clears pending", int'(pending), 0);
        do_cmd(7, 1, 1'b0, 1, "R9 enable responds 1");
        chk_eq("R8 disarm cleared request", int'(pending), 0);

        // R9: code 0 returns previous arm state and changes nothing
        raise(NSRC'(1) << 9);
        do_cmd(9, 0, 1'b1, 1, "R9 no-op returns prev 1");
        do_cmd(9, 0, 1'b0, 0, "R9 no-op returns prev 0");
        chk_eq("R8 no-op keeps request", int'(pending), 1);
        do_ack(dev_of(9), "R8 no-op source still acknowledged");

        // R7: set wins over acknowledge clear
        raise(NSRC'(1) << 10);
        req_set = NSRC'(1) << 10;
        do_ack(dev_of(10), "R7 ack with coincident set");
        chk_eq("R7 set survives clear", int'(pending), 1);
        do_ack(dev_of(10), "R7 second ack of same source");
        chk_eq("R7 cleared afterwards", int'(pending), 0);

        // R10: request-bit update codes
        do_upd(12, 1);
        chk_eq("R10 update set", int'(pending), 1);
        do_upd(12, 0);
        chk_eq("R10 update keep", int'(pending), 1);
        do_upd(12, 3);
        chk_eq("R10 update toggle to 0", int'(pending), 0);
        do_upd(12, 3);
        chk_eq("R10 update toggle to 1", int'(pending), 1);
        do_upd(12, 2);
        chk_eq("R10 update clear", int'(pending), 0);

        // R5: only the winner is cleared
        raise((NSRC'(1) << 20) | (NSRC'(1) << 21));
        do_ack(dev_of(20), "R5 first of two");
        chk_eq("R5 other request kept", int'(pending), 1);
        do_ack(dev_of(21), "R5 second of two");

        // R2: top flat index
        raise(NSRC'(1) << 63);
        do_ack(dev_of(63), "R2 flat index 63");

        step();
        chk_eq("R5 ack queue drained", ack_q.size(), 0);
        chk_eq("R9 response queue drained", rsp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog R1..R12 run actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule